// File: doc/BRIEF.md
# Key-Guarded Flash Program and Erase Sequencer

This block sits between a simple register bus and a small behavioural flash array organised as pages of 16-bit half-words. It runs three kinds of modify operation: programming one half-word, erasing one page, and erasing the whole array. Every operation holds a busy flag for a fixed number of cycles and then either changes the array or reports an error. Software first opens the control register by writing two magic words to a key register. It then chooses an operation through control bits and starts it with a start bit or, for programming, with a half-word write into the array window.

A second key register, opened with the same two words, permits writes to the write-protect register. In that register each bit guards a group of four consecutive pages, and a cleared bit means the group is protected. Two error flags and an end-of-operation flag live in the status register. Software clears each of them by writing a one to its bit.

The bus address is `PAGE`-independent. The most significant bus address bit selects the array window. Below it, the byte address selects a register or an array half-word. Reads return data in the same cycle.

Top module: `kflash_ctrl`

## Requirements
- R1: After reset the control register reads 0x080 (lock bit 7 set, all else clear), status (offset 0x08) reads 0, the write-protect register (offset 0x14) reads all ones, and every array half-word reads 0xFFFF.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key register (offset 0x00) clears the lock bit of the control register (offset 0x0C). Any control write while locked leaves the control register unchanged.
- R3: A key write whose value does not match the expected word for its step keeps the control register locked until the next reset, even if a correct sequence follows.
- R4: A control write with bit 7 set relocks the block and clears the stored operation bits and option write enable. A fresh two-word key sequence unlocks it again.
- R5: Option write enable (control bit 9) sets only after the same two words are written in order to the option key register (offset 0x04) while unlocked. The write-protect register accepts writes only while that bit is set.
- R6: With program enable (control bit 0) set and the block unlocked, an aligned write to the array window (bus address bit 8 set, half-word index in bits 7:1) raises busy (status bit 0) for exactly BUSY_CYCLES cycles. The half-word then holds the low 16 data bits, and end of operation (status bit 5) sets.
- R7: Writing page erase (bit 1), then the page's byte address to the address register (offset 0x10), then page erase with start (bit 6) sets every half-word of that page to 0xFFFF after the busy time and leaves all other pages unchanged.
- R8: Writing mass erase (bit 2) with start sets every half-word of the array to 0xFFFF after the busy time.
- R9: Write-protect bit g guards pages 4g to 4g+3, and a 0 means protected. A program or page erase aimed at a protected page, or a mass erase while any group is protected, leaves the array unchanged and sets write-protect error (status bit 4), not end of operation.
- R10: Programming a half-word that does not read 0xFFFF, or writing to an odd byte address, leaves the array unchanged and sets programming error (status bit 2).
- R11: A status write clears each of bits 2, 4 and 5 where the written data has a one and leaves the others unchanged. When an operation completes in the same cycle, its flag is set and remains set.
- R12: While busy, writes to the control, address and write-protect registers and to the array window are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe for the addressed register or array half-word |
| busRd | input | 1 | Read enable; read data is zero when low |
| busAddr | input | BUS_AW (9) | Byte address; top bit selects the array window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as busRd |

## Verification
The sensitive overlap is a status write landing on the very cycle in which an operation completes and sets one of the flags that write is clearing. The bench counts the cycles from the launching write and places the clearing write exactly on the completion edge, once for end of operation and once for the write-protect error. It expects the flag still set afterwards and cleared by the next identical write. Busy-time writes to control, protection and the array are judged the same way: each lands at a known cycle inside the busy window, and the state is read back at the ports after completion.

// File: rtl/kfc_pkg.sv
package kfc_pkg;

  localparam logic [31:0] KEY_FIRST  = 32'h45670123;
  localparam logic [31:0] KEY_SECOND = 32'hCDEF89AB;

  // register byte offsets inside the register window
  localparam int OFS_KEY     = 0;
  localparam int OFS_OPTKEY  = 4;
  localparam int OFS_STATUS  = 8;
  localparam int OFS_CONTROL = 12;
  localparam int OFS_ADDR    = 16;
  localparam int OFS_WPROT   = 20;

  // control bits
  localparam int CB_PROG     = 0;
  localparam int CB_PAGE     = 1;
  localparam int CB_MASS     = 2;
  localparam int CB_OPTPROG  = 4;
  localparam int CB_OPTERASE = 5;
  localparam int CB_START    = 6;
  localparam int CB_LOCK     = 7;
  localparam int CB_OPTWEN   = 9;

  // status bits
  localparam int SB_BUSY  = 0;
  localparam int SB_PGERR = 2;
  localparam int SB_WPERR = 4;
  localparam int SB_DONE  = 5;

  typedef enum logic [1:0] {KEY_IDLE, KEY_HALF, KEY_OPEN, KEY_DEAD} keyState_t;
  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_PAGE, OP_MASS} opKind_t;

  // strobes from the sequencer to the array datapath
  typedef struct packed {
    logic doProg;
    logic doPage;
    logic doMass;
  } flashStrobe_t;

endpackage

// File: rtl/kfc_keyseq.sv
module kfc_keyseq
  import kfc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        keyWr,
  input  logic        enable,
  input  logic        relock,
  input  logic [31:0] keyData,
  output logic        isOpen
);

  keyState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= KEY_IDLE;
    end else if (relock) begin
      if (state != KEY_DEAD) state <= KEY_IDLE;
    end else if (keyWr && enable) begin
      case (state)
        KEY_IDLE: state <= (keyData == KEY_FIRST)  ? KEY_HALF : KEY_DEAD;
        KEY_HALF: state <= (keyData == KEY_SECOND) ? KEY_OPEN : KEY_DEAD;
        default:  state <= state;
      endcase
    end
  end

  assign isOpen = (state == KEY_OPEN);

  // a wrong key is final until reset
  assert_dead_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == KEY_DEAD) |=> (state == KEY_DEAD));

  // opening always passes through the half-way step
  assert_open_after_half_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isOpen) |-> ($past(state) == KEY_HALF));

endmodule

// File: rtl/kfc_array.sv
module kfc_array
  import kfc_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int PAGE_HW   = 8,
  localparam int HW_TOTAL   = NUM_PAGES * PAGE_HW,
  localparam int HW_AW      = $clog2(HW_TOTAL),
  localparam int PAGE_SHIFT = $clog2(PAGE_HW),
  localparam int PAGE_AW    = HW_AW - PAGE_SHIFT
)(
  input  logic             clk,
  input  logic             rstN,
  input  flashStrobe_t     strobe,
  input  logic [HW_AW-1:0] opHwIdx,
  input  logic [15:0]      opData,
  input  logic [HW_AW-1:0] rdIdx,
  output logic [15:0]      rdData
);

  logic [15:0] cellView [HW_TOTAL];
  logic [PAGE_AW-1:0] opPage;

  assign opPage = opHwIdx[HW_AW-1:PAGE_SHIFT];

  for (genvar i = 0; i < HW_TOTAL; i++) begin : g_cell
    logic [15:0] val;
    logic        hitPage;
    logic        hitCell;
    assign hitPage = strobe.doPage && (opPage == PAGE_AW'(i / PAGE_HW));
    assign hitCell = strobe.doProg && (opHwIdx == HW_AW'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         val <= 16'hFFFF;
      else if (strobe.doMass || hitPage) val <= 16'hFFFF;
      else if (hitCell)                  val <= opData;
    end
    assign cellView[i] = val;
  end

  assign rdData = cellView[rdIdx];

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.doProg, strobe.doPage, strobe.doMass}));

  // the sequencer only programs a cell that is erased
  assert_prog_erased_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doProg |-> (cellView[opHwIdx] == 16'hFFFF));

  assert_mass_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doMass |=> ((cellView[0] == 16'hFFFF) && (cellView[HW_TOTAL-1] == 16'hFFFF)));

endmodule

// File: rtl/kfc_ctrl.sv
module kfc_ctrl
  import kfc_pkg::*;
#(
  parameter int NUM_PAGES       = 16,
  parameter int PAGE_HW         = 8,
  parameter int PAGES_PER_GROUP = 4,
  parameter int BUSY_CYCLES     = 4,
  localparam int HW_TOTAL    = NUM_PAGES * PAGE_HW,
  localparam int HW_AW       = $clog2(HW_TOTAL),
  localparam int ARRAY_AW    = HW_AW + 1,
  localparam int BUS_AW      = ARRAY_AW + 1,
  localparam int PAGE_SHIFT  = $clog2(PAGE_HW),
  localparam int GROUP_SHIFT = $clog2(PAGES_PER_GROUP),
  localparam int NUM_GROUPS  = NUM_PAGES / PAGES_PER_GROUP,
  localparam int GROUP_AW    = HW_AW - PAGE_SHIFT - GROUP_SHIFT,
  localparam int CNT_W       = $clog2(BUSY_CYCLES + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic [15:0]       cellValue,
  output flashStrobe_t      strobe,
  output logic [HW_AW-1:0]  opHwIdx,
  output logic [15:0]       opData,
  output logic [31:0]       regRdata
);

  // ---------------- decode ----------------
  logic                arrSel;
  logic [ARRAY_AW-1:0] regOfs;
  logic wrKey, wrOptKey, wrStatus, wrCtl, wrAddr, wrWprot, wrArr;

  assign arrSel   = busAddr[BUS_AW-1];
  assign regOfs   = busAddr[ARRAY_AW-1:0];
  assign wrKey    = busWr && !arrSel && (regOfs == ARRAY_AW'(OFS_KEY));
  assign wrOptKey = busWr && !arrSel && (regOfs == ARRAY_AW'(OFS_OPTKEY));
  assign wrStatus = busWr && !arrSel && (regOfs == ARRAY_AW'(OFS_STATUS));
  assign wrCtl    = busWr && !arrSel && (regOfs == ARRAY_AW'(OFS_CONTROL));
  assign wrAddr   = busWr && !arrSel && (regOfs == ARRAY_AW'(OFS_ADDR));
  assign wrWprot  = busWr && !arrSel && (regOfs == ARRAY_AW'(OFS_WPROT));
  assign wrArr    = busWr && arrSel;

  // ---------------- key sequencers ----------------
  logic [1:0] keyWrV, enV, relockV, openV;
  logic mainOpen, optOpen, mainRelock;
  logic busy;

  assign mainOpen = openV[0];
  assign optOpen  = openV[1];
  assign keyWrV   = {wrOptKey, wrKey};
  assign enV      = {mainOpen, 1'b1};
  assign relockV  = {mainRelock, mainRelock};

  for (genvar k = 0; k < 2; k++) begin : g_key
    kfc_keyseq u_key (
      .clk     (clk),
      .rstN    (rstN),
      .keyWr   (keyWrV[k]),
      .enable  (enV[k]),
      .relock  (relockV[k]),
      .keyData (busWdata),
      .isOpen  (openV[k])
    );
  end

  // ---------------- registers ----------------
  logic                  progEn, pageEn, massEn, optProgEn, optEraseEn;
  logic [ARRAY_AW-1:0]   addrReg;
  logic [NUM_GROUPS-1:0] wprot;
  logic [CNT_W-1:0]      busyCnt;
  opKind_t               opKind;
  logic                  pendPg, pendWp;
  logic                  pgErr, wpErr, opDone;
  logic                  ctlWrOk;

  assign ctlWrOk    = wrCtl && mainOpen && !busy;
  assign mainRelock = ctlWrOk && busWdata[CB_LOCK];

  function automatic logic [GROUP_AW-1:0] groupOf(input logic [HW_AW-1:0] hw);
    return hw[HW_AW-1 -: GROUP_AW];
  endfunction

  logic [HW_AW-1:0] busHw, addrHw;
  logic launchProg, launchPage, launchMass;
  logic progGuard, pageGuard, massGuard, progBad;

  assign busHw  = busAddr[ARRAY_AW-1:1];
  assign addrHw = addrReg[ARRAY_AW-1:1];

  assign launchProg = wrArr && mainOpen && progEn && !busy;
  assign launchPage = ctlWrOk && !busWdata[CB_LOCK] && busWdata[CB_START]
                      && busWdata[CB_PAGE] && !busWdata[CB_MASS];
  assign launchMass = ctlWrOk && !busWdata[CB_LOCK] && busWdata[CB_START]
                      && busWdata[CB_MASS];

  assign progGuard = wprot[groupOf(busHw)];
  assign pageGuard = wprot[groupOf(addrHw)];
  assign massGuard = &wprot;
  assign progBad   = busAddr[0] || (cellValue != 16'hFFFF);

  logic complete, clean;
  assign complete = busy && (busyCnt == CNT_W'(1));
  assign clean    = !pendPg && !pendWp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progEn     <= 1'b0;
      pageEn     <= 1'b0;
      massEn     <= 1'b0;
      optProgEn  <= 1'b0;
      optEraseEn <= 1'b0;
    end else if (mainRelock) begin
      progEn     <= 1'b0;
      pageEn     <= 1'b0;
      massEn     <= 1'b0;
      optProgEn  <= 1'b0;
      optEraseEn <= 1'b0;
    end else if (ctlWrOk) begin
      progEn     <= busWdata[CB_PROG];
      pageEn     <= busWdata[CB_PAGE];
      massEn     <= busWdata[CB_MASS];
      optProgEn  <= busWdata[CB_OPTPROG];
      optEraseEn <= busWdata[CB_OPTERASE];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      wprot   <= '1;
    end else begin
      if (wrAddr && !busy)            addrReg <= busWdata[ARRAY_AW-1:0];
      if (wrWprot && optOpen && !busy) wprot  <= busWdata[NUM_GROUPS-1:0];
    end
  end

  // operation sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      busyCnt <= '0;
      opKind  <= OP_NONE;
      pendPg  <= 1'b0;
      pendWp  <= 1'b0;
      opHwIdx <= '0;
      opData  <= '0;
    end else if (launchProg) begin
      busy    <= 1'b1;
      busyCnt <= CNT_W'(BUSY_CYCLES);
      opKind  <= OP_PROG;
      opHwIdx <= busHw;
      opData  <= busWdata[15:0];
      pendWp  <= !progGuard;
      pendPg  <= progGuard && progBad;
    end else if (launchPage) begin
      busy    <= 1'b1;
      busyCnt <= CNT_W'(BUSY_CYCLES);
      opKind  <= OP_PAGE;
      opHwIdx <= addrHw;
      pendWp  <= !pageGuard;
      pendPg  <= 1'b0;
    end else if (launchMass) begin
      busy    <= 1'b1;
      busyCnt <= CNT_W'(BUSY_CYCLES);
      opKind  <= OP_MASS;
      pendWp  <= !massGuard;
      pendPg  <= 1'b0;
    end else if (busy) begin
      if (complete) begin
        busy   <= 1'b0;
        opKind <= OP_NONE;
      end
      busyCnt <= busyCnt - CNT_W'(1);
    end
  end

  // status flags: completion set wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgErr  <= 1'b0;
      wpErr  <= 1'b0;
      opDone <= 1'b0;
    end else begin
      pgErr  <= (pgErr  && !(wrStatus && busWdata[SB_PGERR])) || (complete && pendPg);
      wpErr  <= (wpErr  && !(wrStatus && busWdata[SB_WPERR])) || (complete && pendWp);
      opDone <= (opDone && !(wrStatus && busWdata[SB_DONE]))  || (complete && clean);
    end
  end

  assign strobe.doProg = complete && clean && (opKind == OP_PROG);
  assign strobe.doPage = complete && clean && (opKind == OP_PAGE);
  assign strobe.doMass = complete && clean && (opKind == OP_MASS);

  // ---------------- read mux ----------------
  always_comb begin
    regRdata = '0;
    case (regOfs)
      ARRAY_AW'(OFS_STATUS): begin
        regRdata[SB_BUSY]  = busy;
        regRdata[SB_PGERR] = pgErr;
        regRdata[SB_WPERR] = wpErr;
        regRdata[SB_DONE]  = opDone;
      end
      ARRAY_AW'(OFS_CONTROL): begin
        regRdata[CB_PROG]     = progEn;
        regRdata[CB_PAGE]     = pageEn;
        regRdata[CB_MASS]     = massEn;
        regRdata[CB_OPTPROG]  = optProgEn;
        regRdata[CB_OPTERASE] = optEraseEn;
        regRdata[CB_LOCK]     = !mainOpen;
        regRdata[CB_OPTWEN]   = optOpen;
      end
      ARRAY_AW'(OFS_ADDR):  regRdata[ARRAY_AW-1:0]   = addrReg;
      ARRAY_AW'(OFS_WPROT): regRdata[NUM_GROUPS-1:0] = wprot;
      default: regRdata = '0;
    endcase
  end

  // ---------------- assertions ----------------
  logic [4:0] ctlBits;
  assign ctlBits = {progEn, pageEn, massEn, optProgEn, optEraseEn};

  assert_locked_ignore_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtl && !mainOpen) |=> $stable(ctlBits));

  assert_busy_wprot_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrWprot) |=> $stable(wprot));

  assert_done_on_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(opDone) |-> $fell(busy));

  assert_wp_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doProg || strobe.doPage) |-> wprot[groupOf(opHwIdx)]);

endmodule

// File: rtl/kflash_ctrl.sv
module kflash_ctrl
  import kfc_pkg::*;
#(
  parameter int NUM_PAGES       = 16,
  parameter int PAGE_HW         = 8,
  parameter int PAGES_PER_GROUP = 4,
  parameter int BUSY_CYCLES     = 4,
  localparam int HW_AW    = $clog2(NUM_PAGES * PAGE_HW),
  localparam int ARRAY_AW = HW_AW + 1,
  localparam int BUS_AW   = ARRAY_AW + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata
);

  flashStrobe_t     strobe;
  logic [HW_AW-1:0] opHwIdx;
  logic [15:0]      opData;
  logic [15:0]      cellValue;
  logic [31:0]      regRdata;

  kfc_ctrl #(
    .NUM_PAGES       (NUM_PAGES),
    .PAGE_HW         (PAGE_HW),
    .PAGES_PER_GROUP (PAGES_PER_GROUP),
    .BUSY_CYCLES     (BUSY_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .cellValue (cellValue),
    .strobe    (strobe),
    .opHwIdx   (opHwIdx),
    .opData    (opData),
    .regRdata  (regRdata)
  );

  kfc_array #(
    .NUM_PAGES (NUM_PAGES),
    .PAGE_HW   (PAGE_HW)
  ) u_array (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opHwIdx (opHwIdx),
    .opData  (opData),
    .rdIdx   (busAddr[ARRAY_AW-1:1]),
    .rdData  (cellValue)
  );

  assign busRdata = !busRd             ? 32'h0 :
                    busAddr[BUS_AW-1]  ? {16'h0, cellValue} : regRdata;

endmodule

// File: tb/sim_kflash_ctrl.sv
module sim_kflash_ctrl;

  localparam int NP  = 16;
  localparam int PHW = 8;
  localparam int PPG = 4;
  localparam int BC  = 4;
  localparam int HWT = NP * PHW;

  localparam logic [8:0] A_KEY = 9'h000, A_OKEY = 9'h004, A_ST = 9'h008,
                         A_CTL = 9'h00C, A_ADR = 9'h010, A_WP = 9'h014, A_ARR = 9'h100;
  localparam logic [31:0] K1 = 32'h45670123, K2 = 32'hCDEF89AB;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, busWr, busRd;
  logic [8:0]  busAddr;
  logic [31:0] busWdata, busRdata;

  kflash_ctrl #(.NUM_PAGES(NP), .PAGE_HW(PHW), .PAGES_PER_GROUP(PPG), .BUSY_CYCLES(BC)) u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata));

  int checks = 0;
  int errors = 0;
  logic [15:0] model [HWT];
  logic [31:0] d;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] v);
    busWr = 1'b1; busAddr = a; busWdata = v;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] v);
    busRd = 1'b1; busAddr = a;
    #1;
    v = busRdata;
    busRd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkReg(string tag, logic [8:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < HWT; i++) begin
      logic [31:0] v;
      rd(A_ARR | 9'(i * 2), v);
      chk(tag, v, {16'h0, model[i]});
    end
  endtask

  task automatic modelErase();
    for (int i = 0; i < HWT; i++) model[i] = 16'hFFFF;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(1);
    modelErase();
  endtask

  task automatic pageErase(int p);
    wr(A_CTL, 32'h2);
    wr(A_ADR, 32'(p * PHW * 2));
    wr(A_CTL, 32'h42);
    idle(BC);
  endtask

  function automatic logic [15:0] pat(int i);
    return 16'(i * 16'h0101 + 16'h1234);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    busWr = 0; busRd = 0; busAddr = '0; busWdata = '0; rstN = 0;
    @(negedge clk);
    doReset();

    // R1 reset state
    chkReg("R1 control", A_CTL, 32'h080);
    chkReg("R1 status", A_ST, 32'h0);
    chkReg("R1 wprot", A_WP, 32'hF);
    sweep("R1 array erased");

    // R2 locked control write ignored, array write ignored
    wr(A_CTL, 32'h1);
    chkReg("R2 locked ctl", A_CTL, 32'h080);
    wr(A_ARR, 32'h0);
    idle(BC);
    chkReg("R2 locked array", A_ARR, 32'hFFFF);
    chkReg("R2 locked status", A_ST, 32'h0);

    // R3 wrong key is sticky until reset
    wr(A_KEY, K1); wr(A_KEY, 32'h12345678);
    wr(A_KEY, K1); wr(A_KEY, K2);
    chkReg("R3 dead stays locked", A_CTL, 32'h080);
    wr(A_KEY, K2);
    chkReg("R3 wrong order", A_CTL, 32'h080);
    doReset();
    wr(A_KEY, K2); wr(A_KEY, K1);
    chkReg("R3 reversed order", A_CTL, 32'h080);
    doReset();

    // R2 correct unlock
    wr(A_KEY, K1);
    chkReg("R2 half key", A_CTL, 32'h080);
    wr(A_KEY, K2);
    chkReg("R2 unlocked", A_CTL, 32'h000);

    // R5 option keys
    wr(A_WP, 32'h0);
    chkReg("R5 wprot closed", A_WP, 32'hF);
    wr(A_OKEY, K1); wr(A_OKEY, K2);
    chkReg("R5 option open", A_CTL, 32'h200);

    // R10 misaligned program
    wr(A_CTL, 32'h1);
    chkReg("R6 prog enable", A_CTL, 32'h201);
    wr(A_ARR | 9'h001, 32'h0000);
    idle(BC);
    chkReg("R10 misaligned status", A_ST, 32'h04);
    chkReg("R10 misaligned cell", A_ARR, 32'hFFFF);
    wr(A_ST, 32'h04);
    chkReg("R11 pgErr cleared", A_ST, 32'h0);

    // R6 busy window on first program
    wr(A_ARR, {16'hABCD, pat(0)});
    chkReg("R6 busy after launch", A_ST, 32'h01);
    idle(BC - 1);
    chkReg("R6 busy last cycle", A_ST, 32'h01);
    idle(1);
    chkReg("R6 done after busy", A_ST, 32'h20);
    model[0] = pat(0);
    for (int i = 1; i < HWT; i++) begin
      wr(A_ARR | 9'(i * 2), {16'h0, pat(i)});
      idle(BC);
      model[i] = pat(i);
    end
    sweep("R6 program sweep");
    wr(A_ST, 32'h20);
    chkReg("R11 done cleared", A_ST, 32'h0);

    // R10 program a non-erased cell
    wr(A_ARR | 9'h006, 32'h0000);
    idle(BC);
    chkReg("R10 non-erased status", A_ST, 32'h04);
    chkReg("R10 non-erased cell", A_ARR | 9'h006, {16'h0, model[3]});
    wr(A_ST, 32'h24);

    // R7 page erase of page 5
    pageErase(5);
    for (int j = 0; j < PHW; j++) model[5 * PHW + j] = 16'hFFFF;
    chkReg("R7 page erase status", A_ST, 32'h20);
    sweep("R7 page erase sweep");

    // R9 protection sweep over every group
    for (int g = 0; g < NP / PPG; g++) begin
      wr(A_WP, 32'(~(1 << g) & 4'hF));
      chkReg("R5 wprot written", A_WP, 32'(~(1 << g) & 4'hF));
      for (int h = 0; h < NP / PPG; h++) begin
        wr(A_ST, 32'h34);
        pageErase(h * PPG + 1);
        if (h == g) begin
          chkReg("R9 protected erase", A_ST, 32'h10);
        end else begin
          chkReg("R9 open erase", A_ST, 32'h20);
          for (int j = 0; j < PHW; j++) model[(h * PPG + 1) * PHW + j] = 16'hFFFF;
        end
      end
      wr(A_ST, 32'h34);
      wr(A_CTL, 32'h1);
      wr(A_ARR | 9'(g * PPG * PHW * 2), 32'h0000);
      idle(BC);
      chkReg("R9 protected program", A_ST, 32'h10);
      wr(A_ST, 32'h34);
      wr(A_CTL, 32'h4);
      wr(A_CTL, 32'h44);
      idle(BC);
      chkReg("R9 protected mass", A_ST, 32'h10);
      sweep("R9 protection sweep");
      wr(A_ST, 32'h34);
    end

    // R11 same-cycle clear and completion of end-of-operation
    wr(A_WP, 32'hF);
    wr(A_CTL, 32'h1);
    wr(A_ARR | 9'(8 * 2), 32'h1111);
    idle(BC);
    model[8] = 16'h1111;
    chkReg("R11 done set", A_ST, 32'h20);
    wr(A_ST, 32'h14);
    chkReg("R11 zero bits ignored", A_ST, 32'h20);
    wr(A_ARR | 9'(9 * 2), 32'h2222);
    idle(BC - 1);
    wr(A_ST, 32'h20);
    model[9] = 16'h2222;
    chkReg("R11 set wins done", A_ST, 32'h20);
    wr(A_ST, 32'h20);
    chkReg("R11 later clear", A_ST, 32'h0);

    // R11 same-cycle clear and completion of write-protect error
    wr(A_WP, 32'h7);
    wr(A_ARR | 9'(100 * 2), 32'h0000);
    idle(BC);
    chkReg("R9 wp set", A_ST, 32'h10);
    wr(A_ARR | 9'(101 * 2), 32'h0000);
    idle(BC - 1);
    wr(A_ST, 32'h10);
    chkReg("R11 set wins wp", A_ST, 32'h10);
    wr(A_ST, 32'h10);
    chkReg("R11 wp later clear", A_ST, 32'h0);
    sweep("R11 array after collisions");

    // R12 writes during busy
    wr(A_WP, 32'hF);
    wr(A_CTL, 32'h2);
    wr(A_ADR, 32'(2 * PHW * 2));
    wr(A_CTL, 32'h42);
    wr(A_CTL, 32'h1);
    wr(A_WP, 32'h0);
    wr(A_ARR | 9'(40 * 2), 32'h3333);
    idle(BC);
    for (int j = 0; j < PHW; j++) model[2 * PHW + j] = 16'hFFFF;
    chkReg("R12 ctl unchanged", A_CTL, 32'h202);
    chkReg("R12 wprot unchanged", A_WP, 32'hF);
    chkReg("R12 status clean", A_ST, 32'h20);
    chkReg("R12 addr kept", A_ADR, 32'(2 * PHW * 2));
    sweep("R12 array after busy writes");

    // R8 mass erase
    wr(A_CTL, 32'h4);
    wr(A_CTL, 32'h44);
    idle(BC);
    modelErase();
    chkReg("R8 mass status", A_ST, 32'h20);
    sweep("R8 mass sweep");

    // R4 relock and reopen
    wr(A_CTL, 32'h80);
    chkReg("R4 relocked", A_CTL, 32'h080);
    wr(A_CTL, 32'h1);
    chkReg("R4 locked ignores", A_CTL, 32'h080);
    wr(A_ARR, 32'h5555);
    idle(BC);
    chkReg("R4 locked array", A_ARR, 32'hFFFF);
    wr(A_KEY, K1); wr(A_KEY, K2);
    chkReg("R4 reopened", A_CTL, 32'h000);
    wr(A_CTL, 32'h1);
    wr(A_ARR, 32'h5555);
    idle(BC);
    chkReg("R4 program after reopen", A_ARR, 32'h5555);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule